// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This block watches an 8-bit temperature code delivered by an on-chip sensor and turns threshold crossings into interrupt events. Software programs four rising thresholds and four falling thresholds, each packed one byte per level into a 32-bit register. A rise event is recorded when the code climbs to or past a rising level. A fall event is recorded when the code sinks below a falling level. Every event sets a status bit. Each status bit has its own enable, and the interrupt line is the OR of the enabled status bits.

Status is cleared by writing a mask into a separate clear register. Both registers place their bits in the same positions, so software clears exactly what it saw by writing back the status value it read. An emulation register lets software replace the sensor code with a value of its own, which is useful for testing cooling policy. When the control register arms it, a hardware trip output latches as soon as the code reaches the topmost rising level. The trip output then stays high until reset.

Top module: `thermmon_top`

## Requirements
- R1: After reset every register reads zero, and both `irq` and `trip` are low.
- R2: Rising thresholds sit at address 1 and falling thresholds at address 2. Level i occupies bits [8i+7:8i] of each register, and each register reads back what was written.
- R3: With core enable (control bit 0) set, rise status bit i (status bit i) is set one clock after the first cycle in which the effective code is at or above rising level i, having been below it or the core having been off the cycle before. It is not set again while the code stays above.
- R4: With core enable set, fall status bit i (status bit 16+i) is set one clock after the first cycle in which the effective code is below falling level i, having not been below it or the core having been off the cycle before.
- R5: Status reads at address 4. A write to address 5 clears exactly the status bits set in the write data. An event in the same cycle as the clear wins, and other bits are untouched.
- R6: Interrupt enables sit at address 3, rise enables in bits [3:0] and fall enables in bits [19:16]. `irq` is high exactly while some status bit and its enable bit are both set.
- R7: Writing the control register with bit 0 clear zeroes the interrupt-enable register. While the core is off, no status bit is set.
- R8: The emulation register at address 6 holds enable (bit 0), a code (bits [15:8]) and a sampling-time field (bits [31:16]) that reads back and has no effect on comparisons. While the enable is set, the code replaces the sensor input for every comparison. Address 7 reads the effective code.
- R9: With trip enable (control bit 1) and core enable set, an effective code at or above rising level 3 raises `trip` on the next clock. `trip` then stays high until reset, whatever the code or the control register does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sensor_code | input | 8 | Live temperature code from the sensor |
| irq | output | 1 | Level interrupt, OR of enabled status |
| trip | output | 1 | Sticky hardware thermal trip |

## Verification
The bench attacks the edge behaviour of the comparators. Turning the core on while the code already lies beyond several levels must fire all of those events at once. Holding the code above a level after a clear must not fire it again; a level-triggered design would keep the status set. A clear that lands in the same cycle as a new event must keep the new bit; a design that gives the clear priority loses an interrupt. Emulated codes must drive the comparators and the trip latch, and the trip must survive both the code falling away and trip enable being cleared. A design that ties trip to the current level would drop the output.

// File: rtl/thermmon_pkg.sv
package thermmon_pkg;

    localparam int CODE_W   = 8;
    localparam int LEVELS   = 4;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int FALL_OFS = 16;
    localparam int TIME_W   = 16;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_RISE = 4'd1;
    localparam logic [ADDR_W-1:0] A_FALL = 4'd2;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd4;
    localparam logic [ADDR_W-1:0] A_CLR  = 4'd5;
    localparam logic [ADDR_W-1:0] A_EMUL = 4'd6;
    localparam logic [ADDR_W-1:0] A_CODE = 4'd7;

    // control fields
    typedef struct packed {
        logic trip_en;
        logic core_en;
    } ctrl_t;

    // emulation fields
    typedef struct packed {
        logic [TIME_W-1:0] samp_time;
        logic [CODE_W-1:0] code;
        logic              on;
    } emul_t;

    // bits of status / enable that exist
    function automatic logic [DATA_W-1:0] event_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < LEVELS; i++) begin
            m[i]            = 1'b1;
            m[FALL_OFS + i] = 1'b1;
        end
        return m;
    endfunction

    // select one packed byte level
    function automatic logic [CODE_W-1:0] level_of(input logic [DATA_W-1:0] packed_thr,
                                                   input int lvl);
        return packed_thr[lvl*CODE_W +: CODE_W];
    endfunction

endpackage

// File: rtl/thermmon_regs.sv
module thermmon_regs
    import thermmon_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int CW = CODE_W,
    parameter int TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] status_set,
    input  logic [CW-1:0] code_eff,
    output ctrl_t         ctrl_q,
    output logic [DW-1:0] rise_q,
    output logic [DW-1:0] fall_q,
    output logic [DW-1:0] ien_q,
    output logic [DW-1:0] status_q,
    output emul_t         emul_q
);
    localparam logic [DW-1:0] VALID = event_mask();
    localparam int DATA_LSB = 8;
    localparam int TIME_LSB = DATA_LSB + CW;

    logic [DW-1:0] clr_mask;
    logic          core_off_wr;

    assign clr_mask    = (bus_wr && bus_addr == A_CLR) ? (bus_wdata & VALID) : '0;
    assign core_off_wr = bus_wr && bus_addr == A_CTRL && !bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            ien_q    <= '0;
            status_q <= '0;
            emul_q   <= '0;
        end else begin
            // new events take priority over a clear of the same bit
            status_q <= (status_q & ~clr_mask) | (status_set & VALID);
            if (bus_wr) begin
                case (bus_addr)
                    A_CTRL: ctrl_q <= '{trip_en: bus_wdata[1], core_en: bus_wdata[0]};
                    A_RISE: rise_q <= bus_wdata;
                    A_FALL: fall_q <= bus_wdata;
                    A_IEN:  ien_q  <= bus_wdata & VALID;
                    A_EMUL: emul_q <= '{samp_time: bus_wdata[TIME_LSB +: TW],
                                        code:      bus_wdata[DATA_LSB +: CW],
                                        on:        bus_wdata[0]};
                    default: ;
                endcase
            end
            if (core_off_wr)
                ien_q <= '0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = DW'({ctrl_q.trip_en, ctrl_q.core_en});
            A_RISE: bus_rdata = rise_q;
            A_FALL: bus_rdata = fall_q;
            A_IEN:  bus_rdata = ien_q;
            A_STAT: bus_rdata = status_q;
            A_EMUL: begin
                bus_rdata[0]                = emul_q.on;
                bus_rdata[DATA_LSB +: CW]   = emul_q.code;
                bus_rdata[TIME_LSB +: TW]   = emul_q.samp_time;
            end
            A_CODE: bus_rdata = DW'(code_eff);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/thermmon_detect.sv
module thermmon_detect
    import thermmon_pkg::*;
#(
    parameter int NL = LEVELS,
    parameter int CW = CODE_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_en,
    input  logic [CW-1:0] code,
    input  logic [DW-1:0] rise_thr,
    input  logic [DW-1:0] fall_thr,
    output logic [NL-1:0] rise_ev,
    output logic [NL-1:0] fall_ev
);
    logic [NL-1:0] above, below, above_q, below_q;

    for (genvar g = 0; g < NL; g++) begin : g_lvl
        assign above[g]   = code >= level_of(rise_thr, g);
        assign below[g]   = code <  level_of(fall_thr, g);
        assign rise_ev[g] = core_en && above[g] && !above_q[g];
        assign fall_ev[g] = core_en && below[g] && !below_q[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                above_q[g] <= 1'b0;
                below_q[g] <= 1'b0;
            end else begin
                // history forgets itself while monitoring is off
                above_q[g] <= core_en && above[g];
                below_q[g] <= core_en && below[g];
            end
        end
    end
endmodule

// File: rtl/thermmon_trip.sv
module thermmon_trip
    import thermmon_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic [CW-1:0] code,
    input  logic [CW-1:0] top_thr,
    output logic          trip
);
    always_ff @(posedge clk) begin
        if (rst)
            trip <= 1'b0;
        else if (arm && code >= top_thr)
            trip <= 1'b1;
    end
endmodule

// File: rtl/thermmon_top.sv
module thermmon_top
    import thermmon_pkg::*;
#(
    parameter int NL = LEVELS,
    parameter int CW = CODE_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int FO = FALL_OFS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [CW-1:0] sensor_code,
    output logic          irq,
    output logic          trip
);
    ctrl_t         ctrl_q;
    emul_t         emul_q;
    logic [DW-1:0] rise_q, fall_q, ien_q, status_q, status_set;
    logic [CW-1:0] code_eff;
    logic [NL-1:0] rise_ev, fall_ev;
    logic          core_en;

    assign core_en  = ctrl_q.core_en;
    assign code_eff = emul_q.on ? emul_q.code : sensor_code;

    always_comb begin
        status_set = '0;
        status_set[0  +: NL] = rise_ev;
        status_set[FO +: NL] = fall_ev;
    end

    thermmon_regs #(.DW(DW), .AW(AW), .CW(CW), .TW(TIME_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status_set(status_set), .code_eff(code_eff),
        .ctrl_q(ctrl_q), .rise_q(rise_q), .fall_q(fall_q),
        .ien_q(ien_q), .status_q(status_q), .emul_q(emul_q)
    );

    thermmon_detect #(.NL(NL), .CW(CW), .DW(DW)) u_detect (
        .clk(clk), .rst(rst), .core_en(core_en), .code(code_eff),
        .rise_thr(rise_q), .fall_thr(fall_q),
        .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    thermmon_trip #(.CW(CW)) u_trip (
        .clk(clk), .rst(rst),
        .arm(core_en && ctrl_q.trip_en),
        .code(code_eff), .top_thr(level_of(rise_q, NL-1)),
        .trip(trip)
    );

    assign irq = |(status_q & ien_q);
endmodule

// File: rtl/thermmon_chk.sv
module thermmon_chk
    import thermmon_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] status,
    input logic [DATA_W-1:0] ien,
    input logic              core_en,
    input logic              irq,
    input logic              trip
);
    logic clr_wr;
    assign clr_wr = bus_wr && bus_addr == A_CLR;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!trip && status == '0 && ien == '0));

    // R9
    trip_sticky_chk: assert property (@(posedge clk) disable iff (rst) trip |=> trip);

    // R7
    core_off_ien_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CTRL && !bus_wdata[0]) |=> ien == '0);

    // R7
    core_off_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!core_en && !clr_wr) |=> $stable(status));

    // R5
    no_silent_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((status & $past(status)) == $past(status)));

    // R6
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0 && ien != '0));
endmodule

bind thermmon_top thermmon_chk u_chk (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .status(status_q), .ien(ien_q), .core_en(core_en),
    .irq(irq), .trip(trip)
);

// File: tb/thermmon_top_test.sv
module thermmon_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  sensor_code = '0;
    logic        irq, trip;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    thermmon_top uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sensor_code(sensor_code), .irq(irq), .trip(trip)
    );

    // ---------------- behavioural reference ----------------
    localparam logic [31:0] VMASK = 32'h000F_000F;
    int m_core, m_tripen, m_emul_on, m_emul_code, m_emul_time;
    logic [31:0] m_rise, m_fall, m_ien, m_stat;
    bit   m_above[4];
    bit   m_below[4];
    bit   m_trip;

    function automatic int eff_code();
        return m_emul_on ? m_emul_code : int'(sensor_code);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_core = 0; m_tripen = 0; m_emul_on = 0; m_emul_code = 0; m_emul_time = 0;
            m_rise = 0; m_fall = 0; m_ien = 0; m_stat = 0; m_trip = 0;
            for (int i = 0; i < 4; i++) begin m_above[i] = 0; m_below[i] = 0; end
        end else begin
            int c;
            logic [31:0] ev, clr;
            c = eff_code();
            ev = 0;
            for (int i = 0; i < 4; i++) begin
                bit a, b;
                a = c >= int'(m_rise[8*i +: 8]);
                b = c <  int'(m_fall[8*i +: 8]);
                if (m_core != 0 && a && !m_above[i]) ev[i] = 1;
                if (m_core != 0 && b && !m_below[i]) ev[16+i] = 1;
                m_above[i] = (m_core != 0) && a;
                m_below[i] = (m_core != 0) && b;
            end
            if (m_core != 0 && m_tripen != 0 && c >= int'(m_rise[31:24])) m_trip = 1;
            clr = (bus_wr && bus_addr == 4'd5) ? bus_wdata : 32'h0;
            m_stat = (m_stat & ~clr & VMASK) | ev;
            if (bus_wr) begin
                case (bus_addr)
                    4'd0: begin
                        m_core = int'(bus_wdata[0]); m_tripen = int'(bus_wdata[1]);
                    end
                    4'd1: m_rise = bus_wdata;
                    4'd2: m_fall = bus_wdata;
                    4'd3: m_ien = bus_wdata & VMASK;
                    4'd6: begin
                        m_emul_on = int'(bus_wdata[0]);
                        m_emul_code = int'(bus_wdata[15:8]);
                        m_emul_time = int'(bus_wdata[31:16]);
                    end
                    default: ;
                endcase
                if (bus_addr == 4'd0 && !bus_wdata[0]) m_ien = 0;
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return {30'h0, m_tripen[0], m_core[0]};
            4'd1: return m_rise;
            4'd2: return m_fall;
            4'd3: return m_ien;
            4'd4: return m_stat;
            4'd6: return {m_emul_time[15:0], m_emul_code[7:0], 7'h0, m_emul_on[0]};
            4'd7: return 32'(eff_code());
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the outputs (R6 irq, R9 trip)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R6 irq", {31'h0, irq}, {31'h0, |(m_stat & m_ien)});
            check("R9 trip", {31'h0, trip}, {31'h0, m_trip});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a);
        @(negedge clk);
        bus_addr = a;
        #2 check(req, bus_rdata, m_read(a));
    endtask

    task automatic rd_exp(input string req, input logic [3:0] a, input logic [31:0] e);
        @(negedge clk);
        bus_addr = a;
        #2 check(req, bus_rdata, e);
    endtask

    task automatic code(input logic [7:0] v);
        @(negedge clk);
        sensor_code = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd_exp("R1 reset reg", 4'(a), 32'h0);
        check("R1 trip", {31'h0, trip}, 32'h0);
        // R2 packing and readback
        wr(4'd1, 32'hC8_96_64_32);
        wr(4'd2, 32'hBE_8C_5A_28);
        rd_exp("R2 rise", 4'd1, 32'hC8_96_64_32);
        rd_exp("R2 fall", 4'd2, 32'hBE_8C_5A_28);
        // R4 enabling core while cold: all falls fire at once
        code(8'd10);
        wr(4'd3, 32'h000F_000F);
        wr(4'd0, 32'h1);
        idle(2);
        rd_exp("R4 fall on enable", 4'd4, 32'h000F_0000);
        // R5 write back what was read
        wr(4'd5, 32'h000F_0000);
        idle(1);
        rd_exp("R5 cleared", 4'd4, 32'h0);
        // R3 rise past levels 0 and 1, no retrigger while staying above
        code(8'd120);
        idle(2);
        rd_exp("R3 rise 0,1", 4'd4, 32'h0000_0003);
        wr(4'd5, 32'h0000_0001);
        idle(3);
        rd_exp("R3 no retrigger", 4'd4, 32'h0000_0002);
        wr(4'd5, 32'h0000_0002);
        // R4 fall below levels 0 and 1 only
        code(8'd30);
        idle(2);
        rd_exp("R4 fall 0,1", 4'd4, 32'h0003_0000);
        wr(4'd5, 32'h0003_0000);
        // R5 clear racing a new event: event wins
        @(negedge clk);
        sensor_code = 8'd60;
        bus_wr = 1'b1; bus_addr = 4'd5; bus_wdata = 32'h0000_0001;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        rd_exp("R5 set beats clear", 4'd4, 32'h0000_0001);
        wr(4'd5, 32'h0000_0001);
        // R6 partial enable
        wr(4'd3, 32'h0000_0004);
        code(8'd160);
        idle(2);
        rd("R6 status", 4'd4);
        check("R6 irq on bit2", {31'h0, irq}, 32'h1);
        wr(4'd5, 32'h0000_0004);
        idle(1);
        check("R6 irq drop", {31'h0, irq}, 32'h0);
        // R8 emulation overrides the sensor and arms R9 trip
        wr(4'd0, 32'h3);
        wr(4'd6, 32'h1234_D201);
        idle(2);
        rd_exp("R8 emul readback", 4'd6, 32'h1234_D201);
        rd_exp("R8 effective code", 4'd7, 32'h0000_00D2);
        rd("R8 emul rise", 4'd4);
        check("R9 trip set", {31'h0, trip}, 32'h1);
        s = m_read(4'd4);
        wr(4'd5, s);
        wr(4'd6, 32'h0000_0000);
        code(8'd20);
        wr(4'd0, 32'h1);
        idle(3);
        rd_exp("R8 sensor back", 4'd7, 32'h0000_0014);
        check("R9 trip sticky", {31'h0, trip}, 32'h1);
        // R7 core off zeroes enables and freezes status
        s = m_read(4'd4);
        wr(4'd5, s);
        wr(4'd3, 32'h000F_000F);
        wr(4'd0, 32'h0);
        rd_exp("R7 ien zeroed", 4'd3, 32'h0);
        code(8'd250);
        idle(3);
        code(8'd0);
        idle(3);
        rd_exp("R7 no events when off", 4'd4, 32'h0);
        check("R7 irq low", {31'h0, irq}, 32'h0);
        // R3 re-enable while hot fires rises on enable
        code(8'd170);
        wr(4'd0, 32'h1);
        idle(2);
        rd("R3 rise on enable", 4'd4);
        idle(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule